// File: doc/BRIEF.md
# Line-Buffered 2-D 5/3 Lifting Wavelet Engine

This block computes one decomposition level of a separable, integer-to-integer 5/3 lifting wavelet transform. Pixels enter in raster order, one per accepted transfer. Coefficients leave one per accepted transfer, and each carries a two-bit subband tag. A row stage turns each row into interleaved low-pass and high-pass coefficients. A column stage starts filtering as soon as the rows it needs are present. Storage stays at a few lines of width `IMG_W` and never grows to a whole frame.

The column stage keeps three lines: the last even row, the last odd row and the previous column high-pass line. The odd row is held in two FIFOs, one for the low-pass band and one for the high-pass band. These FIFOs are drained while the next even row arrives. At image edges a missing neighbour is replaced by its mirror sample. After the last row of a frame, the column stage runs one internal flush pass to emit the final row pair. During that pass it stops accepting input.

Both streams use valid/ready. A transfer takes place on a rising clock edge where valid and ready are both high. While `out_valid` is high and `out_ready` is low, the coefficient and its tag stay frozen. `in_ready` falls whenever the internal queues cannot take the coefficients the next pixel might produce. It also falls during the flush pass. Nothing is dropped under back-pressure.

Top module: `wav53_line_engine`

## Requirements
- R1: For each row x of width `IMG_W`, the row stage produces d[n] = x[2n+1] - floor((x[2n]+x[2n+2])/2) at odd column 2n+1 and s[n] = x[2n] + floor((d[n-1]+d[n]+2)/4) at even column 2n.
- R2: On each column of the row-filtered data r, the column stage forms high-pass D[m] from odd row 2m+1 as r[2m+1] - floor((r[2m]+r[2m+2])/2), and low-pass S[m] on even row 2m as r[2m] + floor((D[m-1]+D[m]+2)/4).
- R3: At edges, a missing sample is mirrored. x[IMG_W] is replaced by x[IMG_W-2] and d[-1] by d[0]. The same rule applies vertically: r[IMG_H] is replaced by r[IMG_H-2] and D[-1] by D[0].
- R4: Output order is row pair m = 0..IMG_H/2-1, then column j = 0..IMG_W-1, with S[m][j] first and D[m][j] second. The tag is {vertical-high, horizontal-high}, so LL=0, HL=1, LH=2 and HH=3. Bit 0 of the tag is j odd; bit 1 is set for D and clear for S.
- R5: `out_next_level` is high exactly for LL coefficients (tag 0).
- R6: While `out_valid` is high and `out_ready` is low, `out_coef` and `out_band` hold their values. A pixel is taken only on a cycle with `in_valid` and `in_ready` both high. Any stall pattern yields the same coefficient sequence.
- R7: Pixels are unsigned `PIX_W` bits. Coefficients are signed `PIX_W+2` bits, and no value overflows for any image, including alternating extremes.
- R8: The first coefficient of a frame is delivered before the last pixel of that frame is accepted.
- R9: Frames follow one another with no reset in between. Each frame is transformed independently.
- R10: After reset, `out_valid` is low and `in_ready` is high.
- R11: Each frame yields exactly `IMG_W*IMG_H` coefficients. The count of coefficients delivered never exceeds the count of pixels accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel present on `in_pix` |
| in_ready | output | 1 | Engine can take a pixel this cycle |
| in_pix | input | PIX_W | Unsigned pixel, raster order |
| out_valid | output | 1 | Coefficient present |
| out_ready | input | 1 | Consumer takes the coefficient |
| out_coef | output | PIX_W+2 | Signed wavelet coefficient |
| out_band | output | 2 | Subband tag: LL=0, HL=1, LH=2, HH=3 |
| out_next_level | output | 1 | Coefficient belongs to the next-level input (LL) |

## Verification
The bench builds the engine with an 8-bit pixel and a 6 by 6 image. This size exercises both mirrored edges in each direction. It also covers an interior row pair that reuses a stored column high-pass value, FIFO wrap-around, and the final flush pass, all within a few hundred cycles. Every delivered coefficient, tag and next-level flag is compared with an integer model, for flat, ramp, alternating-extreme and random images. These runs mix input gaps, heavy output back-pressure and back-to-back frames.

// File: rtl/wav53_pkg.sv
`timescale 1ns/1ps
package wav53_pkg;

  typedef enum logic [1:0] {
    BAND_LL = 2'd0,
    BAND_HL = 2'd1,
    BAND_LH = 2'd2,
    BAND_HH = 2'd3
  } band_e;

  // High-pass lifting step: odd sample minus floor of neighbour mean.
  function automatic int lift_pred(int odd_s, int ev_l, int ev_r);
    return odd_s - ((ev_l + ev_r) >>> 1);
  endfunction

  // Low-pass lifting step: even sample plus rounded quarter of two highs.
  function automatic int lift_upd(int ev, int hi_l, int hi_r);
    return ev + ((hi_l + hi_r + 2) >>> 2);
  endfunction

endpackage

// File: rtl/wav53_pairq.sv
`timescale 1ns/1ps
// Two-entry queue: takes zero, one or two items per cycle, gives one.
module wav53_pairq #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    push_n,
  input  logic [DW-1:0] d0,
  input  logic [DW-1:0] d1,
  input  logic          pop,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          room2
);
  logic [DW-1:0] q0, q1, n0, n1;
  logic [1:0]    cnt, nc;

  assign out_valid = (cnt != 2'd0);
  assign out_data  = q0;
  assign room2     = (cnt == 2'd0) || (cnt == 2'd1 && pop);

  always_comb begin
    n0 = q0;
    n1 = q1;
    nc = cnt;
    if (pop && cnt != 2'd0) begin
      n0 = q1;
      nc = cnt - 2'd1;
    end
    if (push_n != 2'd0) begin
      if (nc == 2'd0) n0 = d0;
      else            n1 = d0;
      nc = nc + 2'd1;
    end
    if (push_n == 2'd2) begin
      n1 = d1;
      nc = nc + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= 2'd0;
    else     cnt <= nc;
    q0 <= n0;
    q1 <= n1;
  end
endmodule

// File: rtl/wav53_bandfifo.sv
`timescale 1ns/1ps
// Holds one band (half a row) of the pending odd row.
module wav53_bandfifo #(
  parameter int DW    = 10,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  assign dout = mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= (int'(wp) == DEPTH - 1) ? '0 : wp + 1'b1;
      if (pop)  rp <= (int'(rp) == DEPTH - 1) ? '0 : rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end
endmodule

// File: rtl/wav53_row.sv
`timescale 1ns/1ps
// Horizontal lifting: emits s[n], d[n] pairs in column order.
module wav53_row
  import wav53_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 10,
  parameter int IMG_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [PIX_W-1:0]         in_pix,
  output logic                     in_ready,
  output logic                     rc_valid,
  output logic signed [COEF_W-1:0] rc_data,
  input  logic                     rc_ready
);
  localparam int CW = (IMG_W > 2) ? $clog2(IMG_W) : 1;

  logic [CW-1:0]            col;
  logic signed [COEF_W-1:0] xe, xo, dprev, px, ev_r, od, d, s, dl;
  logic                     room2, take, last, first, emit;
  logic [1:0]               push_n;

  assign px       = $signed({{(COEF_W - PIX_W){1'b0}}, in_pix});
  assign in_ready = room2;
  assign take     = in_valid && in_ready;
  assign last     = (int'(col) == IMG_W - 1);

  always_comb begin
    od     = col[0] ? px : xo;
    ev_r   = col[0] ? xe : px;              // right edge mirrors x[2n]
    d      = COEF_W'(lift_pred(int'(od), int'(xe), int'(ev_r)));
    first  = (int'(col) <= 2);
    dl     = first ? d : dprev;             // left edge mirrors d[0]
    s      = COEF_W'(lift_upd(int'(xe), int'(dl), int'(d)));
    emit   = take && (col[0] ? last : (col != '0));
    push_n = emit ? 2'd2 : 2'd0;
  end

  always_ff @(posedge clk) begin
    if (rst)       col <= '0;
    else if (take) col <= last ? '0 : col + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      if (col[0]) xo <= px;
      else        xe <= px;
    end
    if (emit) dprev <= d;
  end

  wav53_pairq #(.DW(COEF_W)) u_q (
    .clk       (clk),
    .rst       (rst),
    .push_n    (push_n),
    .d0        (s),
    .d1        (d),
    .pop       (rc_valid && rc_ready),
    .out_valid (rc_valid),
    .out_data  (rc_data),
    .room2     (room2)
  );
endmodule

// File: rtl/wav53_col.sv
`timescale 1ns/1ps
// Vertical lifting over row coefficients with three stored lines.
module wav53_col
  import wav53_pkg::*;
#(
  parameter int COEF_W = 10,
  parameter int IMG_W  = 16,
  parameter int IMG_H  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rc_valid,
  input  logic signed [COEF_W-1:0] rc_data,
  output logic                     rc_ready,
  output logic                     out_valid,
  output logic signed [COEF_W-1:0] out_coef,
  output logic [1:0]               out_band,
  input  logic                     out_ready
);
  localparam int CW   = (IMG_W > 2) ? $clog2(IMG_W) : 1;
  localparam int RW   = (IMG_H > 2) ? $clog2(IMG_H) : 1;
  localparam int HALF = IMG_W / 2;
  localparam int QW   = COEF_W + 2;

  logic [CW-1:0]            col;
  logic [RW-1:0]            row;
  logic                     flushing;
  logic signed [COEF_W-1:0] even_row [IMG_W];
  logic signed [COEF_W-1:0] dl_row   [IMG_W];
  logic [COEF_W-1:0]        fout     [2];
  logic signed [COEF_W-1:0] r0, r1, r2, dv, sv, dsel;
  logic                     room2, take, step, fire, lastc, first;
  logic [1:0]               push_n;
  logic [QW-1:0]            q_d0, q_d1, q_out;

  assign rc_ready = !flushing && room2;
  assign take     = rc_valid && rc_ready;
  assign step     = flushing && room2;
  assign fire     = step || (take && !row[0] && row != '0);
  assign lastc    = (int'(col) == IMG_W - 1);

  generate
    for (genvar b = 0; b < 2; b++) begin : g_band
      wav53_bandfifo #(.DW(COEF_W), .DEPTH(HALF)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .push (take && row[0] && (int'(col[0]) == b)),
        .din  (rc_data),
        .pop  (fire && (int'(col[0]) == b)),
        .dout (fout[b])
      );
    end
  endgenerate

  always_comb begin
    r0     = even_row[col];
    r1     = $signed(fout[col[0]]);
    r2     = flushing ? r0 : rc_data;      // bottom edge mirrors r[2m]
    dv     = COEF_W'(lift_pred(int'(r1), int'(r0), int'(r2)));
    first  = flushing ? (IMG_H == 2) : (int'(row) == 2);
    dsel   = first ? dv : dl_row[col];     // top edge mirrors D[0]
    sv     = COEF_W'(lift_upd(int'(r0), int'(dsel), int'(dv)));
    q_d0   = {1'b0, col[0], sv};
    q_d1   = {1'b1, col[0], dv};
    push_n = fire ? 2'd2 : 2'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col      <= '0;
      row      <= '0;
      flushing <= 1'b0;
    end else if (take || step) begin
      col <= lastc ? '0 : col + 1'b1;
      if (lastc) begin
        if (flushing) begin
          flushing <= 1'b0;
        end else if (int'(row) == IMG_H - 1) begin
          flushing <= 1'b1;
          row      <= '0;
        end else begin
          row <= row + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take && !row[0]) even_row[col] <= rc_data;
    if (fire)            dl_row[col]   <= dv;
  end

  wav53_pairq #(.DW(QW)) u_q (
    .clk       (clk),
    .rst       (rst),
    .push_n    (push_n),
    .d0        (q_d0),
    .d1        (q_d1),
    .pop       (out_valid && out_ready),
    .out_valid (out_valid),
    .out_data  (q_out),
    .room2     (room2)
  );

  assign out_band = q_out[QW-1:COEF_W];
  assign out_coef = $signed(q_out[COEF_W-1:0]);
endmodule

// File: rtl/wav53_line_engine.sv
`timescale 1ns/1ps
module wav53_line_engine
  import wav53_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int IMG_W  = 16,
  parameter int IMG_H  = 16,
  localparam int COEF_W = PIX_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [PIX_W-1:0]         in_pix,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [COEF_W-1:0] out_coef,
  output logic [1:0]               out_band,
  output logic                     out_next_level
);
  logic                     rc_valid, rc_ready;
  logic signed [COEF_W-1:0] rc_data;

  wav53_row #(.PIX_W(PIX_W), .COEF_W(COEF_W), .IMG_W(IMG_W)) u_row (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_pix   (in_pix),
    .in_ready (in_ready),
    .rc_valid (rc_valid),
    .rc_data  (rc_data),
    .rc_ready (rc_ready)
  );

  wav53_col #(.COEF_W(COEF_W), .IMG_W(IMG_W), .IMG_H(IMG_H)) u_col (
    .clk       (clk),
    .rst       (rst),
    .rc_valid  (rc_valid),
    .rc_data   (rc_data),
    .rc_ready  (rc_ready),
    .out_valid (out_valid),
    .out_coef  (out_coef),
    .out_band  (out_band),
    .out_ready (out_ready)
  );

  assign out_next_level = (out_band == BAND_LL);
endmodule

// File: rtl/wav53_chk.sv
`timescale 1ns/1ps
module wav53_chk #(
  parameter int COEF_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [COEF_W-1:0] out_coef,
  input logic [1:0]        out_band
);
  logic [31:0] n_in, n_out;
  logic        have_last;
  logic [1:0]  last_band;
  logic        xfer;

  assign xfer = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_in      <= '0;
      n_out     <= '0;
      have_last <= 1'b0;
      last_band <= 2'd0;
    end else begin
      if (in_valid && in_ready) n_in <= n_in + 1;
      if (xfer) begin
        n_out     <= n_out + 1;
        last_band <= out_band;
        have_last <= 1'b1;
      end
    end
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_coef) && $stable(out_band)));

  // R4
  hi_after_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && have_last && !last_band[1]) |-> (out_band == {1'b1, last_band[0]}));

  // R4
  lo_after_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && have_last && last_band[1]) |-> !out_band[1]);

  // R11
  no_outrun_chk: assert property (@(posedge clk) disable iff (rst)
    xfer |-> (n_out < n_in));

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    $fell(rst) |-> !out_valid);
endmodule

bind wav53_line_engine wav53_chk #(.COEF_W(COEF_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_coef  (out_coef),
  .out_band  (out_band)
);

// File: tb/tb_wav53_line_engine.sv
`timescale 1ns/1ps
module tb_wav53_line_engine;
  localparam int PW   = 8;
  localparam int IW   = 6;
  localparam int IH   = 6;
  localparam int NPIX = IW * IH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [PW-1:0] in_pix = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [PW+1:0] out_coef;
  logic [1:0] out_band;
  logic out_next_level;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int pix_sent = 0;
  int img [IH][IW];
  int exp_c [NPIX];
  int exp_b [NPIX];

  wav53_line_engine #(.PIX_W(PW), .IMG_W(IW), .IMG_H(IH)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
    .out_coef(out_coef), .out_band(out_band), .out_next_level(out_next_level)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int pr(int o, int l, int r);
    return o - ((l + r) >>> 1);
  endfunction

  function automatic int up(int e, int a, int b);
    return e + ((a + b + 2) >>> 2);
  endfunction

  task automatic model();
    int rc [IH][IW];
    int dd [IW/2];
    int dc [IH/2];
    int k = 0;
    for (int y = 0; y < IH; y++) begin
      for (int n = 0; n < IW/2; n++)
        dd[n] = pr(img[y][2*n+1], img[y][2*n], (2*n+2 < IW) ? img[y][2*n+2] : img[y][2*n]);
      for (int n = 0; n < IW/2; n++) begin
        rc[y][2*n]   = up(img[y][2*n], (n == 0) ? dd[0] : dd[n-1], dd[n]);
        rc[y][2*n+1] = dd[n];
      end
    end
    for (int m = 0; m < IH/2; m++) begin
      for (int j = 0; j < IW; j++) begin
        for (int mm = 0; mm <= m; mm++)
          dc[mm] = pr(rc[2*mm+1][j], rc[2*mm][j], (2*mm+2 < IH) ? rc[2*mm+2][j] : rc[2*mm][j]);
        exp_c[k] = up(rc[2*m][j], (m == 0) ? dc[0] : dc[m-1], dc[m]);
        exp_b[k] = j % 2;
        k++;
        exp_c[k] = dc[m];
        exp_b[k] = 2 + (j % 2);
        k++;
      end
    end
  endtask

  task automatic fill(input int kind);
    for (int y = 0; y < IH; y++)
      for (int x = 0; x < IW; x++)
        case (kind)
          0: img[y][x] = 128;
          1: img[y][x] = x * 40 + y * 3;
          2: img[y][x] = ((x + y) % 2) * 255;
          default: img[y][x] = int'($urandom_range(255));
        endcase
  endtask

  task automatic run_frame(input string rq, input int gap, input int bp, input bit want_early);
    int got_c [NPIX];
    int got_b [NPIX];
    int got_f [NPIX];
    int ngot = 0;
    int first_at = -1;
    int deadline = cyc + 20000;
    model();
    pix_sent = 0;
    fork
      begin : drv
        int k = 0;
        while (k < NPIX && cyc < deadline) begin
          @(negedge clk);
          if (int'($urandom_range(99)) < gap) in_valid = 1'b0;
          else begin
            in_valid = 1'b1;
            in_pix = PW'(img[k / IW][k % IW]);
          end
          #1;
          if (in_valid && in_ready) begin
            k++;
            pix_sent = k;
          end
        end
        @(negedge clk);
        in_valid = 1'b0;
      end
      begin : mon
        while (ngot < NPIX && cyc < deadline) begin
          @(negedge clk);
          out_ready = (int'($urandom_range(99)) >= bp);
          #1.5;
          if (out_valid && out_ready) begin
            got_c[ngot] = int'(out_coef);
            got_b[ngot] = int'(out_band);
            got_f[ngot] = int'(out_next_level);
            if (ngot == 0) first_at = pix_sent;
            ngot++;
          end
        end
      end
    join
    check(ngot == NPIX, "R11 watchdog/count", ngot, NPIX);
    for (int i = 0; i < ngot; i++) begin
      check(got_c[i] == exp_c[i], rq, got_c[i], exp_c[i]);
      check(got_b[i] == exp_b[i], "R4", got_b[i], exp_b[i]);
      check(got_f[i] == int'(exp_b[i] == 0), "R5", got_f[i], int'(exp_b[i] == 0));
    end
    if (want_early) check(first_at >= 0 && first_at < NPIX, "R8", first_at, NPIX - 1);
    @(negedge clk);
    out_ready = 1'b1;
    repeat (8) @(negedge clk);
    #1.5;
    check(!out_valid, "R11 no extra output", int'(out_valid), 0);
  endtask

  task automatic t_reset();
    #1.5;
    check(!out_valid, "R10 out_valid", int'(out_valid), 0);
    check(in_ready, "R10 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_flat();   fill(0); run_frame("R1 flat", 0, 0, 1'b1);    endtask
  task automatic t_ramp();   fill(1); run_frame("R3 ramp", 0, 0, 1'b0);    endtask
  task automatic t_extreme(); fill(2); run_frame("R7 extremes", 10, 0, 1'b0); endtask
  task automatic t_random(); fill(3); run_frame("R2 random", 30, 0, 1'b1); endtask
  task automatic t_backpressure(); fill(3); run_frame("R6 stalls", 20, 70, 1'b0); endtask
  task automatic t_two_frames();
    fill(3); run_frame("R9 frame A", 0, 20, 1'b0);
    fill(1); run_frame("R9 frame B", 0, 0, 1'b0);
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_flat();
    t_ramp();
    t_extreme();
    t_random();
    t_backpressure();
    t_two_frames();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule